// File: doc/BRIEF.md
# Watchdog Timer with Warning Pulse

This block watches a software strobe line, `wdi`, and raises an alarm when the strobe stops. Any change of level on `wdi` counts as a strobe, whether it rises or falls. If the line keeps one level for longer than the timeout, two active-low alarms fire. The first is a short warning pulse on `wdpo_n`. A few clock cycles later a level flag, `wdo_n`, drops and stays low until the next strobe arrives. While the strobe stays silent, the timer keeps running and emits a fresh warning pulse at the end of each further timeout period.

The timeout is counted in prescaled ticks. A tick is a clock enable produced every `PRESCALE` clocks. The timeout length is either a fixed default count or the programmed value `tmo_prog` multiplied by a per-unit tick count. With the default parameters (a 125 MHz clock and 0.1 ms ticks), the default is 1.6 s and each programmed unit is worth 2.1 ms. Two inputs can silence the block:
- `wdi_float` marks the strobe line as unconnected and disables the function.
- `reset_active` marks a system reset in progress. It holds the level flag inactive and the timer idle.

Top module: `wdt_pulse_watchdog`

## Requirements
In what follows, L is the timeout in ticks and P is `PRESCALE`. Edge n is the first rising clock edge at which a new `wdi` level is present at the input.

- R1: A `wdi` change restarts the timeout. This holds for rising and falling changes alike. Strobes spaced closer than L·P clocks keep both outputs high.
- R2: With `tmo_sel`=0, L is `DEFAULT_TICKS`. After the last `wdi` change at edge n, `wdpo_n` goes low after edge n+3+L·P.
- R3: With `tmo_sel`=1, L is `tmo_prog`·`TICKS_PER_UNIT`. A `tmo_prog` of 0 is treated as an L of 1 tick.
- R4: `wdo_n` goes low exactly `LEAD_CYCLES` clocks after `wdpo_n` goes low for the same timeout.
- R5: A single timeout holds `wdpo_n` low for exactly `PULSE_CYCLES` clocks. A further timeout during the pulse restarts that width.
- R6: Once low, `wdo_n` stays low until the next `wdi` change. It returns high after edge n+2.
- R7: While `wdi` stays constant, a further `wdpo_n` pulse starts every L·P clocks after the previous one, and `wdo_n` stays low.
- R8: While `wdi_float`=1, both outputs are high from the next edge, and `wdi` changes are ignored. If `wdi_float` is last high at edge m, the next pulse starts after edge m+1+L·P.
- R9: While `reset_active`=1, `wdo_n` is high from the next edge and no timeout occurs. If it is last high at edge m, the next pulse starts after edge m+1+L·P.
- R10: While `rst`=1, both outputs are high. Timing starts from the last reset edge, as it does in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wdi | input | 1 | Strobe line (asynchronous, synchronised inside) |
| wdi_float | input | 1 | 1: strobe line unconnected, function disabled |
| tmo_sel | input | 1 | 0: default timeout, 1: programmed timeout |
| tmo_prog | input | UNIT_W | Programmed timeout in units |
| reset_active | input | 1 | 1: system reset asserted, level flag held high |
| wdo_n | output | 1 | Sticky timeout flag, active low |
| wdpo_n | output | 1 | Warning pulse, active low |

## Verification
An internal fault in this block shows up as a timing error at the two outputs, and it shows quickly.
- A timeout counter that fails to clear on a strobe makes `wdpo_n` fall before its predicted edge within one period.
- A wrong limit shifts that edge by whole ticks.
- A broken lead or pulse counter moves the fall of `wdo_n` or the rise of `wdpo_n` by a few clocks.

Because of this, every expectation is an exact cycle number relative to the strobe change or release that produced it. The scenarios cover both strobe polarities, both timeout sources, the zero-value clamp, and each of the two silencing inputs.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic {
    SRC_DEFAULT = 1'b0,
    SRC_PROG    = 1'b1
  } tmo_src_e;

  // Bits needed for a value of at least 1.
  function automatic int bits_for(input int unsigned value);
    return (value > 1) ? $clog2(value + 1) : 1;
  endfunction

  // Width of the tick counter so that both timeout sources fit.
  function automatic int cnt_bits(input int unit_w, input int unsigned per_unit,
                                  input int unsigned dflt);
    int prod_w;
    int dflt_w;
    prod_w = unit_w + bits_for(per_unit);
    dflt_w = bits_for(dflt);
    return (prod_w > dflt_w) ? prod_w : dflt_w;
  endfunction

endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic changed
);
  logic [STAGES-1:0] chain;
  logic              prev;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign changed = chain[STAGES-1] ^ prev;

endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int PRESCALE = 12500
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_MAX = PW'(PRESCALE - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst || restart)      pre <= '0;
    else if (pre == PRE_MAX) pre <= '0;
    else                     pre <= pre + 1'b1;
  end

  assign tick = (pre == PRE_MAX);

endmodule

// File: rtl/wdt_timeout_ctr.sv
module wdt_timeout_ctr
  import wdt_pkg::*;
#(
  parameter int UNIT_W         = 16,
  parameter int TICKS_PER_UNIT = 21,
  parameter int DEFAULT_TICKS  = 16000,
  parameter int CNT_W          = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              tick,
  input  logic              tmo_sel,
  input  logic [UNIT_W-1:0] tmo_prog,
  output logic              fire,
  output logic [CNT_W-1:0]  count
);
  localparam logic [CNT_W-1:0] DFLT  = CNT_W'(DEFAULT_TICKS);
  localparam logic [CNT_W-1:0] SCALE = CNT_W'(TICKS_PER_UNIT);

  tmo_src_e         src;
  logic [CNT_W-1:0] prod;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] last;

  assign src  = tmo_src_e'(tmo_sel);
  assign prod = CNT_W'(tmo_prog) * SCALE;

  always_comb begin
    if (src == SRC_PROG) limit = (prod == '0) ? CNT_W'(1) : prod;
    else                 limit = DFLT;
    last = limit - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      count <= '0;
      fire  <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (tick) begin
        if (count >= last) begin
          count <= '0;
          fire  <= 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/wdt_out_stage.sv
module wdt_out_stage #(
  parameter int PULSE_CYCLES = 125000,
  parameter int LEAD_CYCLES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic clear_level,
  input  logic kill_pulse,
  output logic wdo_n,
  output logic wdpo_n
);
  localparam int PC_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam int LD_W = $clog2(LEAD_CYCLES + 1);
  localparam logic [PC_W-1:0] PC_LOAD = PC_W'(PULSE_CYCLES - 1);
  localparam logic [LD_W-1:0] LD_LOAD = LD_W'(LEAD_CYCLES);

  logic [PC_W-1:0] pcnt;
  logic [LD_W-1:0] lead;

  // Warning pulse: minimum width, retriggered by a new timeout.
  always_ff @(posedge clk) begin
    if (rst || kill_pulse) begin
      wdpo_n <= 1'b1;
      pcnt   <= '0;
    end else if (fire) begin
      wdpo_n <= 1'b0;
      pcnt   <= PC_LOAD;
    end else if (pcnt != '0) begin
      pcnt <= pcnt - 1'b1;
    end else begin
      wdpo_n <= 1'b1;
    end
  end

  // Sticky level flag, delayed behind the pulse by the lead counter.
  always_ff @(posedge clk) begin
    if (rst || clear_level) begin
      wdo_n <= 1'b1;
      lead  <= '0;
    end else begin
      if (lead == LD_W'(1)) wdo_n <= 1'b0;
      if (fire)             lead  <= LD_LOAD;
      else if (lead != '0)  lead  <= lead - 1'b1;
    end
  end

endmodule

// File: rtl/wdt_pulse_watchdog.sv
module wdt_pulse_watchdog
  import wdt_pkg::*;
#(
  parameter int PRESCALE       = 12500,
  parameter int DEFAULT_TICKS  = 16000,
  parameter int TICKS_PER_UNIT = 21,
  parameter int UNIT_W         = 16,
  parameter int PULSE_CYCLES   = 125000,
  parameter int LEAD_CYCLES    = 2,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wdi,
  input  logic              wdi_float,
  input  logic              tmo_sel,
  input  logic [UNIT_W-1:0] tmo_prog,
  input  logic              reset_active,
  output logic              wdo_n,
  output logic              wdpo_n
);
  localparam int CNT_W = cnt_bits(UNIT_W, TICKS_PER_UNIT, DEFAULT_TICKS);

  logic             sync_edge;
  logic             hold;
  logic             restart;
  logic             tick;
  logic             tmr_fire;
  logic [CNT_W-1:0] tmr_count;

  assign hold    = wdi_float | reset_active;
  assign restart = sync_edge | hold;

  wdt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .din     (wdi),
    .changed (sync_edge)
  );

  wdt_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .tick    (tick)
  );

  wdt_timeout_ctr #(
    .UNIT_W         (UNIT_W),
    .TICKS_PER_UNIT (TICKS_PER_UNIT),
    .DEFAULT_TICKS  (DEFAULT_TICKS),
    .CNT_W          (CNT_W)
  ) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .tick     (tick),
    .tmo_sel  (tmo_sel),
    .tmo_prog (tmo_prog),
    .fire     (tmr_fire),
    .count    (tmr_count)
  );

  wdt_out_stage #(
    .PULSE_CYCLES (PULSE_CYCLES),
    .LEAD_CYCLES  (LEAD_CYCLES)
  ) u_out (
    .clk         (clk),
    .rst         (rst),
    .fire        (tmr_fire),
    .clear_level (restart),
    .kill_pulse  (wdi_float),
    .wdo_n       (wdo_n),
    .wdpo_n      (wdpo_n)
  );

endmodule

// File: rtl/wdt_pulse_watchdog_chk.sv
module wdt_pulse_watchdog_chk #(
  parameter int PULSE_CYCLES = 6,
  parameter int LEAD_CYCLES  = 2,
  parameter int CNT_W        = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wdi_float,
  input logic             reset_active,
  input logic             wdo_n,
  input logic             wdpo_n,
  input logic             sync_edge,
  input logic             tmr_fire,
  input logic [CNT_W-1:0] tmr_count
);
  localparam int SF_W = $clog2(LEAD_CYCLES + 2) + 1;
  localparam int LR_W = $clog2(PULSE_CYCLES + 2) + 1;
  localparam logic [SF_W-1:0] SF_MAX = SF_W'(LEAD_CYCLES + 1);
  localparam logic [LR_W-1:0] LR_MAX = LR_W'(PULSE_CYCLES);

  logic [SF_W-1:0] since_fire;
  logic [LR_W-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst)                    since_fire <= SF_MAX;
    else if (tmr_fire)          since_fire <= '0;
    else if (since_fire != SF_MAX) since_fire <= since_fire + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || wdpo_n)          low_run <= '0;
    else if (low_run != LR_MAX) low_run <= low_run + 1'b1;
  end

  assert_rst_idle_R10: assert property (@(posedge clk)
    rst |=> (wdo_n && wdpo_n));

  assert_edge_restart_R1: assert property (@(posedge clk) disable iff (rst)
    sync_edge |=> (tmr_count == '0));

  assert_lead_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(wdo_n) |-> (since_fire == SF_W'(LEAD_CYCLES)));

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(wdpo_n) |-> ((low_run >= LR_MAX) || $past(wdi_float)));

  assert_level_release_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(wdo_n) |-> $past(sync_edge || wdi_float || reset_active));

  assert_float_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    wdi_float |=> (wdo_n && wdpo_n));

  assert_hold_level_R9: assert property (@(posedge clk) disable iff (rst)
    reset_active |=> wdo_n);

endmodule

bind wdt_pulse_watchdog wdt_pulse_watchdog_chk #(
  .PULSE_CYCLES (PULSE_CYCLES),
  .LEAD_CYCLES  (LEAD_CYCLES),
  .CNT_W        (CNT_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wdi_float    (wdi_float),
  .reset_active (reset_active),
  .wdo_n        (wdo_n),
  .wdpo_n       (wdpo_n),
  .sync_edge    (sync_edge),
  .tmr_fire     (tmr_fire),
  .tmr_count    (tmr_count)
);

// File: tb/tb_wdt_pulse_watchdog.sv
module tb_wdt_pulse_watchdog;
  localparam int PRE  = 4;
  localparam int DFLT = 10;
  localparam int TPU  = 3;
  localparam int PW   = 6;
  localparam int LEAD = 2;
  localparam int UW   = 8;
  localparam int LP   = PRE * DFLT;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wdi = 1'b0;
  logic          wdi_float = 1'b0;
  logic          tmo_sel = 1'b0;
  logic [UW-1:0] tmo_prog = '0;
  logic          reset_active = 1'b0;
  logic          wdo_n;
  logic          wdpo_n;

  wdt_pulse_watchdog #(
    .PRESCALE       (PRE),
    .DEFAULT_TICKS  (DFLT),
    .TICKS_PER_UNIT (TPU),
    .UNIT_W         (UW),
    .PULSE_CYCLES   (PW),
    .LEAD_CYCLES    (LEAD),
    .SYNC_STAGES    (2)
  ) dut (
    .clk          (clk),
    .rst          (rst),
    .wdi          (wdi),
    .wdi_float    (wdi_float),
    .tmo_sel      (tmo_sel),
    .tmo_prog     (tmo_prog),
    .reset_active (reset_active),
    .wdo_n        (wdo_n),
    .wdpo_n       (wdpo_n)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    bit    is_pulse;
    bit    val;
    string tag;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  task automatic expect_out(input int at, input bit is_pulse, input bit val, input string tag);
    exp_t e;
    e.at = at;
    e.is_pulse = is_pulse;
    e.val = val;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Timing restarted at edge c+3: pulse falls after c+4+lp, level LEAD later.
  task automatic expect_timeout(input int c, input int lp, input string tag);
    expect_out(c + 3 + lp, 1'b1, 1'b1, tag);
    expect_out(c + 4 + lp, 1'b1, 1'b0, tag);
    expect_out(c + 3 + lp + LEAD, 1'b0, 1'b1, {tag, " R4"});
    expect_out(c + 4 + lp + LEAD, 1'b0, 1'b0, {tag, " R4"});
  endtask

  task automatic wait_to(input int n);
    do @(negedge clk); while (cyc < n);
  endtask

  // Monitor: pop every expectation due this cycle and compare.
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        logic act;
        act = sb[i].is_pulse ? wdpo_n : wdo_n;
        checks++;
        if (act !== sb[i].val) begin
          fails++;
          $display("FAIL %s cycle=%0d %s actual=%0b expected=%0b", sb[i].tag, cyc,
                   sb[i].is_pulse ? "wdpo_n" : "wdo_n", act, sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at cycle %0d actual=hung expected=finished", cyc);
    finish_run();
  end

  initial begin
    // R10: outputs idle in reset, timing counts from last reset edge (3)
    expect_out(2, 1'b0, 1'b1, "R10");
    expect_out(2, 1'b1, 1'b1, "R10");
    wait_to(3);
    rst = 1'b0;
    expect_timeout(0, LP, "R2 R10");
    expect_out(49, 1'b1, 1'b0, "R5");
    expect_out(50, 1'b1, 1'b1, "R5");
    expect_out(83, 1'b1, 1'b1, "R7");
    expect_out(84, 1'b1, 1'b0, "R7");
    expect_out(84, 1'b0, 1'b0, "R7");
    expect_out(89, 1'b0, 1'b0, "R6");

    // R6 / R1: rising change releases the flag and restarts timing
    wait_to(90);
    expect_out(92, 1'b0, 1'b0, "R6");
    expect_out(93, 1'b0, 1'b1, "R6");
    wdi = ~wdi;
    expect_timeout(90, LP, "R1 rising");

    // R1: falling change also counts
    wait_to(140);
    expect_out(142, 1'b0, 1'b0, "R1 falling");
    expect_out(143, 1'b0, 1'b1, "R1 falling");
    wdi = ~wdi;

    // R1: strobes closer than the timeout keep both outputs high
    wait_to(170);
    wdi = ~wdi;
    expect_out(180, 1'b0, 1'b1, "R1");
    expect_out(180, 1'b1, 1'b1, "R1");
    wait_to(200);
    wdi = ~wdi;
    wait_to(230);
    wdi = ~wdi;
    expect_out(250, 1'b0, 1'b1, "R1");
    expect_out(250, 1'b1, 1'b1, "R1");
    expect_timeout(230, LP, "R2");
    expect_out(280, 1'b1, 1'b1, "R5");

    // R3: programmed timeout of 5 units
    wait_to(300);
    tmo_sel  = 1'b1;
    tmo_prog = 8'd5;
    wdi = ~wdi;
    expect_out(303, 1'b0, 1'b1, "R6");
    expect_timeout(300, 5 * TPU * PRE, "R3");

    // R3: zero programmed value acts as one tick; R7 repeats keep pulse low
    wait_to(400);
    tmo_prog = 8'd0;
    wdi = ~wdi;
    expect_out(403, 1'b0, 1'b1, "R3");
    expect_timeout(400, PRE, "R3 zero");
    expect_out(430, 1'b1, 1'b0, "R7");

    // R9: reset_active holds the flag high and stops timeouts
    wait_to(450);
    tmo_sel = 1'b0;
    reset_active = 1'b1;
    wdi = ~wdi;
    expect_out(451, 1'b0, 1'b1, "R9");
    expect_out(455, 1'b1, 1'b1, "R9");
    expect_out(520, 1'b0, 1'b1, "R9");
    expect_out(520, 1'b1, 1'b1, "R9");
    wait_to(560);
    reset_active = 1'b0;
    expect_timeout(557, LP, "R9");

    // R8: floating strobe silences both outputs and ignores changes
    wait_to(643);
    wdi_float = 1'b1;
    expect_out(644, 1'b0, 1'b1, "R8");
    expect_out(644, 1'b1, 1'b1, "R8");
    wait_to(700);
    wdi = ~wdi;
    expect_out(705, 1'b0, 1'b1, "R8");
    expect_out(705, 1'b1, 1'b1, "R8");
    expect_out(740, 1'b0, 1'b1, "R8");
    expect_out(740, 1'b1, 1'b1, "R8");
    wait_to(760);
    wdi_float = 1'b0;
    expect_timeout(757, LP, "R8");

    wait_to(820);
    if (sb.size() != 0) begin
      fails += sb.size();
      $display("FAIL scoreboard actual=%0d pending expected=0", sb.size());
    end
    finish_run();
  end

endmodule